// File: doc/BRIEF.md
# QoS bandwidth usage monitor

This block is the monitoring-control side of a quality-of-service bandwidth controller. Software issues a monitoring request by presenting a one-cycle request strobe together with an operation code, an event code, a monitoring counter index (MCID), an access-type-valid flag and an access type. The block validates the request in a fixed order, then either reprograms the selected per-MCID counter or copies it into a readable result register, and reports a status code. Any register front end that sits on the bus can drive this interface.

A traffic-observation port reports memory accesses as they happen. Each report carries a byte count, a read/write flag, the issuing MCID and the access type. Every active counter whose MCID, event class and optional access-type filter match the access adds its byte count, and stops at full scale rather than wrapping.

The control path is a two-state machine. In `IDLE` the block waits. The transition *accept* (request strobe while idle) latches the request fields and moves to `EXEC`, where `busy` is high. The transition *complete* always returns to `IDLE` at the next edge, and it commits the counter update, the status code and the result register in that same edge.

Top module: `qos_bw_monitor`

## Requirements
- R1: A request is taken only when `busy` is low. `busy` is then high for exactly one cycle, and status and the result register change only at the edge that ends that cycle. A strobe while `busy` is high is ignored.
- R2: An MCID greater than or equal to `NUM_MCID` returns status 3 (invalid MCID). This check comes before every other check.
- R3: The operation codes are 1 = configure-event and 2 = read-counter, each valid only when its capability bit (`CAP_OP` bit 0 and bit 1) is set. Any other code returns status 2 (invalid operation).
- R4: For configure-event, the event codes are 0 = none, 1 = read+write bytes, 2 = read bytes and 3 = write bytes, each valid only when `CAP_EVT` bit n is set. Any other code returns status 4 (invalid event), and this check comes before the access-type check.
- R5: Configure-event with event 0 deactivates the counter, keeps its value and returns status 1, whatever the access-type fields hold. An inactive counter ignores traffic.
- R6: A byte-count configure with the access-type-valid flag set and an access type other than 0 (data) or 1 (code) returns status 5 and leaves the counter unchanged.
- R7: A successful byte-count configure returns status 1. It clears the counter to zero, sets its INVALID flag, activates it and stores the event class and the access-type filter.
- R8: An active counter adds the byte count of each access with its MCID that matches its class (read+write: every access; read: `tr_write`=0; write: `tr_write`=1) and, when a filter is stored, its access type. The first such access clears INVALID. A configure of the same counter in the same edge takes precedence.
- R9: A counter saturates at 2^`CNT_W`-1.
- R10: Read-counter returns status 1 and copies the counter value and INVALID flag, as they were before that edge, into `cnt_val`/`cnt_invalid`. It ignores the event and access-type fields.
- R11: After reset, `busy`, `status` (0 = no result yet), `cnt_val` and `cnt_invalid` are zero, and every counter is inactive, at zero and valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code |
| req_evt | input | 3 | Event code |
| req_mcid | input | MCID_W | Target counter index |
| req_atv | input | 1 | Access-type filter enable |
| req_at | input | 2 | Access type (0 data, 1 code) |
| tr_valid | input | 1 | Traffic report valid |
| tr_bytes | input | BYTES_W | Bytes moved by the access |
| tr_write | input | 1 | 1 for a write, 0 for a read |
| tr_mcid | input | MCID_W | MCID of the access |
| tr_at | input | 2 | Access type of the access |
| busy | output | 1 | Request in execution |
| status | output | 3 | Result code of the last request |
| cnt_val | output | CNT_W | Counter value captured by read-counter |
| cnt_invalid | output | 1 | INVALID flag captured by read-counter |

## Verification
Requests are driven with every failure cause, alone and in combination, so that the status code shows which check fires first: an out-of-range MCID with a bad opcode, and a bad event code with a bad access type. Traffic is mixed across reads and writes, data and code, and neighbouring MCIDs. This separates the three event classes and the filtered and unfiltered counters, and it shows that deactivated counters stay unchanged. A long run of large accesses drives one counter to saturation. A second strobe placed in the busy cycle shows whether a request raised while busy is dropped. A behavioural model checks every output on every clock.

// File: rtl/qbm_pkg.sv
package qbm_pkg;

    typedef enum logic [2:0] {
        ST_NONE     = 3'd0,
        ST_OK       = 3'd1,
        ST_BAD_OP   = 3'd2,
        ST_BAD_MCID = 3'd3,
        ST_BAD_EVT  = 3'd4,
        ST_BAD_AT   = 3'd5
    } qbm_status_e;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_TOTAL  = 2'd1,
        EV_READS  = 2'd2,
        EV_WRITES = 2'd3
    } qbm_evt_e;

    localparam logic [2:0] OP_CFG  = 3'd1;
    localparam logic [2:0] OP_READ = 3'd2;
    localparam logic [1:0] AT_MAX  = 2'd1;

    typedef struct packed {
        logic     load;
        logic     activate;
        qbm_evt_e cls;
        logic     atv;
        logic [1:0] at;
    } qbm_cfg_t;

endpackage

// File: rtl/qbm_req_check.sv
module qbm_req_check
    import qbm_pkg::*;
#(
    parameter int          NUM_MCID = 8,
    parameter int          MCID_W   = 4,
    parameter logic [1:0]  CAP_OP   = 2'b11,
    parameter logic [3:0]  CAP_EVT  = 4'b1111
) (
    input  logic [2:0]        op,
    input  logic [2:0]        evt,
    input  logic [MCID_W-1:0] mcid,
    input  logic              atv,
    input  logic [1:0]        at,
    output qbm_status_e       result,
    output qbm_cfg_t          cfg,
    output logic              is_read
);

    logic op_cfg_ok;
    logic op_rd_ok;
    logic evt_ok;
    logic mcid_bad;

    always_comb begin
        op_cfg_ok = (op == OP_CFG)  && CAP_OP[0];
        op_rd_ok  = (op == OP_READ) && CAP_OP[1];
        evt_ok    = (evt[2] == 1'b0) && CAP_EVT[evt[1:0]];
        mcid_bad  = (int'(mcid) >= NUM_MCID);
    end

    always_comb begin
        result  = ST_OK;
        cfg     = '0;
        is_read = 1'b0;
        if (mcid_bad) begin
            result = ST_BAD_MCID;
        end else if (!(op_cfg_ok || op_rd_ok)) begin
            result = ST_BAD_OP;
        end else if (op_rd_ok) begin
            is_read = 1'b1;
        end else if (!evt_ok) begin
            result = ST_BAD_EVT;
        end else if (evt[1:0] == EV_NONE) begin
            cfg.load     = 1'b1;
            cfg.activate = 1'b0;
        end else if (atv && (at > AT_MAX)) begin
            result = ST_BAD_AT;
        end else begin
            cfg.load     = 1'b1;
            cfg.activate = 1'b1;
            cfg.cls      = qbm_evt_e'(evt[1:0]);
            cfg.atv      = atv;
            cfg.at       = at;
        end
    end

endmodule

// File: rtl/qbm_counter_bank.sv
module qbm_counter_bank
    import qbm_pkg::*;
#(
    parameter int NUM_MCID = 8,
    parameter int MCID_W   = 4,
    parameter int CNT_W    = 12,
    parameter int BYTES_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [MCID_W-1:0]  cfg_idx,
    input  qbm_cfg_t           cfg,
    input  logic               tr_valid,
    input  logic [BYTES_W-1:0] tr_bytes,
    input  logic               tr_write,
    input  logic [MCID_W-1:0]  tr_mcid,
    input  logic [1:0]         tr_at,
    input  logic [MCID_W-1:0]  rd_idx,
    output logic [CNT_W-1:0]   rd_val,
    output logic               rd_inv
);

    localparam int PAD_W = CNT_W + 1 - BYTES_W;

    logic [CNT_W-1:0] val_a [NUM_MCID];
    logic             inv_a [NUM_MCID];

    for (genvar i = 0; i < NUM_MCID; i++) begin : g_ctr
        logic             act_q;
        logic             inv_q;
        logic             atv_q;
        qbm_evt_e         cls_q;
        logic [1:0]       at_q;
        logic [CNT_W-1:0] val_q;
        logic             cls_hit;
        logic             hit;
        logic             cfg_hit;
        logic [CNT_W:0]   sum;

        always_comb begin
            unique case (cls_q)
                EV_TOTAL:  cls_hit = 1'b1;
                EV_READS:  cls_hit = !tr_write;
                EV_WRITES: cls_hit = tr_write;
                default:   cls_hit = 1'b0;
            endcase
            hit = tr_valid && act_q && cls_hit
                  && (tr_mcid == MCID_W'(i))
                  && (!atv_q || (tr_at == at_q));
            sum     = {1'b0, val_q} + {{PAD_W{1'b0}}, tr_bytes};
            cfg_hit = cfg_we && (cfg_idx == MCID_W'(i));
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                act_q <= 1'b0;
                inv_q <= 1'b0;
                atv_q <= 1'b0;
                cls_q <= EV_NONE;
                at_q  <= '0;
                val_q <= '0;
            end else if (cfg_hit) begin
                act_q <= cfg.activate;
                if (cfg.activate) begin
                    inv_q <= 1'b1;
                    val_q <= '0;
                    cls_q <= cfg.cls;
                    atv_q <= cfg.atv;
                    at_q  <= cfg.at;
                end
            end else if (hit) begin
                inv_q <= 1'b0;
                val_q <= sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
            end
        end

        assign val_a[i] = val_q;
        assign inv_a[i] = inv_q;
    end

    always_comb begin
        rd_val = '0;
        rd_inv = 1'b0;
        for (int i = 0; i < NUM_MCID; i++) begin
            if (rd_idx == MCID_W'(i)) begin
                rd_val = val_a[i];
                rd_inv = inv_a[i];
            end
        end
    end

endmodule

// File: rtl/qos_bw_monitor.sv
module qos_bw_monitor
    import qbm_pkg::*;
#(
    parameter int         NUM_MCID = 8,
    parameter int         MCID_W   = 4,
    parameter int         CNT_W    = 12,
    parameter int         BYTES_W  = 8,
    parameter logic [1:0] CAP_OP   = 2'b11,
    parameter logic [3:0] CAP_EVT  = 4'b1111
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [2:0]         req_op,
    input  logic [2:0]         req_evt,
    input  logic [MCID_W-1:0]  req_mcid,
    input  logic               req_atv,
    input  logic [1:0]         req_at,
    input  logic               tr_valid,
    input  logic [BYTES_W-1:0] tr_bytes,
    input  logic               tr_write,
    input  logic [MCID_W-1:0]  tr_mcid,
    input  logic [1:0]         tr_at,
    output logic               busy,
    output logic [2:0]         status,
    output logic [CNT_W-1:0]   cnt_val,
    output logic               cnt_invalid
);

    typedef enum logic {S_IDLE, S_EXEC} state_e;

    state_e            state_q, state_d;
    logic [2:0]        op_q, evt_q;
    logic [MCID_W-1:0] mcid_q;
    logic              atv_q;
    logic [1:0]        at_q;

    qbm_status_e       chk_result;
    qbm_cfg_t          chk_cfg;
    logic              chk_read;
    logic              cfg_we;
    logic [CNT_W-1:0]  bank_val;
    logic              bank_inv;

    qbm_status_e       status_q;
    logic [CNT_W-1:0]  rval_q;
    logic              rinv_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req_valid) state_d = S_EXEC;
            S_EXEC: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            evt_q  <= '0;
            mcid_q <= '0;
            atv_q  <= 1'b0;
            at_q   <= '0;
        end else if (state_q == S_IDLE && req_valid) begin
            op_q   <= req_op;
            evt_q  <= req_evt;
            mcid_q <= req_mcid;
            atv_q  <= req_atv;
            at_q   <= req_at;
        end
    end

    qbm_req_check #(
        .NUM_MCID (NUM_MCID),
        .MCID_W   (MCID_W),
        .CAP_OP   (CAP_OP),
        .CAP_EVT  (CAP_EVT)
    ) u_check (
        .op      (op_q),
        .evt     (evt_q),
        .mcid    (mcid_q),
        .atv     (atv_q),
        .at      (at_q),
        .result  (chk_result),
        .cfg     (chk_cfg),
        .is_read (chk_read)
    );

    assign cfg_we = (state_q == S_EXEC) && chk_cfg.load;

    qbm_counter_bank #(
        .NUM_MCID (NUM_MCID),
        .MCID_W   (MCID_W),
        .CNT_W    (CNT_W),
        .BYTES_W  (BYTES_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_idx  (mcid_q),
        .cfg      (chk_cfg),
        .tr_valid (tr_valid),
        .tr_bytes (tr_bytes),
        .tr_write (tr_write),
        .tr_mcid  (tr_mcid),
        .tr_at    (tr_at),
        .rd_idx   (mcid_q),
        .rd_val   (bank_val),
        .rd_inv   (bank_inv)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= ST_NONE;
            rval_q   <= '0;
            rinv_q   <= 1'b0;
        end else if (state_q == S_EXEC) begin
            status_q <= chk_result;
            if (chk_read) begin
                rval_q <= bank_val;
                rinv_q <= bank_inv;
            end
        end
    end

    assign busy        = (state_q == S_EXEC);
    assign status      = status_q;
    assign cnt_val     = rval_q;
    assign cnt_invalid = rinv_q;

endmodule

// File: rtl/qbm_checker.sv
module qbm_checker #(
    parameter int NUM_MCID = 8,
    parameter int MCID_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [MCID_W-1:0] req_mcid,
    input logic              busy,
    input logic [2:0]        status
);

    AST_BUSY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy); // R1

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy); // R1

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(status)); // R1

    AST_MCID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && (int'(req_mcid) >= NUM_MCID)) |=> ##1 (status == 3'd3)); // R2

    AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        status <= 3'd5); // R3

endmodule

bind qos_bw_monitor qbm_checker #(
    .NUM_MCID (NUM_MCID),
    .MCID_W   (MCID_W)
) u_qbm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_mcid  (req_mcid),
    .busy      (busy),
    .status    (status)
);

// File: tb/qos_bw_monitor_tb.sv
module qos_bw_monitor_tb;

    localparam int NUM = 8;
    localparam int MW  = 4;
    localparam int CW  = 12;
    localparam int BW  = 8;
    localparam int FULL = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0, req_evt = '0;
    logic [MW-1:0] req_mcid = '0;
    logic          req_atv = 1'b0;
    logic [1:0]    req_at = '0;
    logic          tr_valid = 1'b0;
    logic [BW-1:0] tr_bytes = '0;
    logic          tr_write = 1'b0;
    logic [MW-1:0] tr_mcid = '0;
    logic [1:0]    tr_at = '0;
    logic          busy;
    logic [2:0]    status;
    logic [CW-1:0] cnt_val;
    logic          cnt_invalid;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    qos_bw_monitor #(.NUM_MCID(NUM), .MCID_W(MW), .CNT_W(CW), .BYTES_W(BW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_evt(req_evt), .req_mcid(req_mcid), .req_atv(req_atv), .req_at(req_at),
        .tr_valid(tr_valid), .tr_bytes(tr_bytes), .tr_write(tr_write),
        .tr_mcid(tr_mcid), .tr_at(tr_at), .busy(busy), .status(status),
        .cnt_val(cnt_val), .cnt_invalid(cnt_invalid));

    // behavioural reference model
    bit m_act[NUM], m_inv[NUM], m_atv[NUM];
    int m_cls[NUM], m_at[NUM], m_val[NUM];
    bit m_busy, m_rinv;
    int m_status, m_rval;
    int p_op, p_evt, p_mcid, p_at;
    bit p_atv;

    always @(posedge clk or negedge rst_n) begin
        int  cfg_i;
        bit  cfg_on;
        bit  was_busy;
        if (!rst_n) begin
            for (int i = 0; i < NUM; i++) begin
                m_act[i] = 0; m_inv[i] = 0; m_atv[i] = 0;
                m_cls[i] = 0; m_at[i] = 0; m_val[i] = 0;
            end
            m_busy = 0; m_rinv = 0; m_status = 0; m_rval = 0;
        end else begin
            cfg_i = -1; cfg_on = 0; was_busy = m_busy;
            if (m_busy) begin
                m_busy = 0;
                if (p_mcid >= NUM) m_status = 3;
                else if (p_op == 2) begin
                    m_status = 1; m_rval = m_val[p_mcid]; m_rinv = m_inv[p_mcid];
                end else if (p_op != 1) m_status = 2;
                else if (p_evt > 3) m_status = 4;
                else if (p_evt == 0) begin m_status = 1; cfg_i = p_mcid; cfg_on = 0; end
                else if (p_atv && p_at > 1) m_status = 5;
                else begin m_status = 1; cfg_i = p_mcid; cfg_on = 1; end
            end
            if (tr_valid && int'(tr_mcid) < NUM && int'(tr_mcid) != cfg_i) begin
                int k;
                bit cls_ok;
                k = int'(tr_mcid);
                cls_ok = (m_cls[k] == 1) || (m_cls[k] == 2 && !tr_write) || (m_cls[k] == 3 && tr_write);
                if (m_act[k] && cls_ok && (!m_atv[k] || m_at[k] == int'(tr_at))) begin
                    m_inv[k] = 0;
                    m_val[k] = m_val[k] + int'(tr_bytes);
                    if (m_val[k] > FULL) m_val[k] = FULL;
                end
            end
            if (cfg_i >= 0) begin
                m_act[cfg_i] = cfg_on;
                if (cfg_on) begin
                    m_inv[cfg_i] = 1; m_val[cfg_i] = 0; m_cls[cfg_i] = p_evt;
                    m_atv[cfg_i] = p_atv; m_at[cfg_i] = p_at;
                end
            end
            if (!was_busy && req_valid) begin
                m_busy = 1; p_op = req_op; p_evt = req_evt; p_mcid = int'(req_mcid);
                p_atv = req_atv; p_at = req_at;
            end
        end
    end

    function automatic string status_tag(int s);
        case (s)
            1: return "R7";
            2: return "R3";
            3: return "R2";
            4: return "R4";
            5: return "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == m_busy, "R1 busy", busy, m_busy);
            check(int'(status) == m_status, status_tag(m_status), status, m_status);
            check(int'(cnt_val) == m_rval, (m_rval == FULL) ? "R9 cnt" : "R8 cnt", cnt_val, m_rval);
            check(cnt_invalid == m_rinv, "R10 invalid", cnt_invalid, m_rinv);
        end
    end

    task automatic do_req(int op, int evt, int mcid, bit atv, int at);
        @(negedge clk);
        req_valid = 1; req_op = 3'(op); req_evt = 3'(evt);
        req_mcid = MW'(mcid); req_atv = atv; req_at = 2'(at);
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
    endtask

    task automatic traffic(int bytes, bit wr, int mcid, int at);
        @(negedge clk);
        tr_valid = 1; tr_bytes = BW'(bytes); tr_write = wr;
        tr_mcid = MW'(mcid); tr_at = 2'(at);
        @(negedge clk);
        tr_valid = 0;
    endtask

    task automatic expect_read(int mcid, int val, bit inv, string tag);
        do_req(2, 0, mcid, 0, 0);
        check(int'(cnt_val) == val, tag, cnt_val, val);
        check(cnt_invalid == inv, tag, cnt_invalid, inv);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        check(busy == 0, "R11", busy, 0);
        check(status == 0, "R11", status, 0);
        check(cnt_val == 0 && cnt_invalid == 0, "R11", cnt_val, 0);

        do_req(1, 1, 8, 0, 0);
        check(status == 3, "R2 mcid range", status, 3);
        do_req(5, 7, 9, 1, 3);
        check(status == 3, "R2 checked first", status, 3);
        do_req(0, 1, 0, 0, 0);
        check(status == 2, "R3 op 0", status, 2);
        do_req(7, 1, 0, 0, 0);
        check(status == 2, "R3 op 7", status, 2);
        do_req(1, 5, 0, 0, 0);
        check(status == 4, "R4 bad event", status, 4);
        do_req(1, 4, 0, 1, 3);
        check(status == 4, "R4 before access type", status, 4);
        do_req(1, 1, 0, 1, 2);
        check(status == 5, "R6 bad access type", status, 5);
        expect_read(0, 0, 0, "R6 counter untouched");

        do_req(1, 1, 0, 0, 0);
        check(status == 1, "R7 config ok", status, 1);
        expect_read(0, 0, 1, "R7 cleared and invalid");
        traffic(10, 0, 0, 0);
        traffic(20, 1, 0, 1);
        traffic(5, 0, 1, 0);
        expect_read(0, 30, 0, "R8 total class");

        do_req(1, 2, 1, 1, 1);
        traffic(7, 0, 1, 1);
        traffic(9, 1, 1, 1);
        traffic(11, 0, 1, 0);
        expect_read(1, 7, 0, "R8 reads with code filter");

        do_req(1, 3, 2, 0, 0);
        traffic(3, 1, 2, 0);
        traffic(4, 0, 2, 1);
        expect_read(2, 3, 0, "R8 writes only");

        do_req(1, 0, 0, 1, 3);
        check(status == 1, "R5 deactivate ok", status, 1);
        traffic(50, 0, 0, 0);
        expect_read(0, 30, 0, "R5 inactive holds value");

        do_req(1, 1, 3, 0, 0);
        for (int n = 0; n < 20; n++) traffic(255, n[0], 3, 0);
        expect_read(3, FULL, 0, "R9 saturation");

        do_req(2, 7, 1, 1, 3);
        check(status == 1 && cnt_val == 7, "R10 fields ignored", cnt_val, 7);

        // R1: strobe during busy is dropped
        @(negedge clk);
        req_valid = 1; req_op = 3'd2; req_mcid = MW'(2);
        @(negedge clk);
        check(busy == 1, "R1 busy", busy, 1);
        req_op = 3'd1; req_evt = 3'd1; req_mcid = MW'(2);
        @(negedge clk);
        req_valid = 0;
        check(busy == 0 && cnt_val == 3, "R1 second strobe ignored", cnt_val, 3);
        expect_read(2, 3, 0, "R1 counter not reconfigured");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule